// File: doc/BRIEF.md
# Serial Display Command Decoder

This block accepts 8-bit command bytes from a three-wire serial link and turns them into the stored state of an eight-character, 5x5 dot-matrix display controller. The link has a serial clock (`sdclk`), a data line (`sdata`) and a framing strobe (`load`). While `load` is low, each rising edge of `sdclk` shifts one data bit into an 8-bit shift register, least significant bit first. The byte is interpreted only when `load` returns high.

The top three bits of the byte select what happens to the lower five. Opcodes 0 to 4 write a row of five dots into a 40-entry by 5-bit user memory, at the character currently addressed. Opcode 5 sets the character address. Opcodes 6 and 7 carry control words: software clear, seven brightness levels, lamp test and power down. A multiplex and scan engine outside this block reads the memory through a combinational read port. It also takes the address, brightness, lamp-test and power-down registers as plain outputs.

All three serial inputs are asynchronous to `clk` and are brought in through synchronizer chains. Edges are then detected in the `clk` domain, so `clk` must run at least four times faster than `sdclk`.

Top module: `sdd_cmd_decoder`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the following are cleared: every memory cell becomes 0, the shift register becomes 0, `char_addr` becomes 0, `bright_lvl` becomes 0 (full brightness), and `lamp_test`, `power_down` and `wr_en` become 0.
- R2: A bit from `sdata` enters the shift register on each rising edge of `sdclk` seen while `load` is low. The new bit enters at bit 7 and existing bits move toward bit 0, so the first bit sent ends up as D0. Rising edges of `sdclk` while `load` is high change nothing.
- R3: Commands are acted on only at a rising edge of `load`. At all other times `char_addr`, `bright_lvl`, `lamp_test` and `power_down` hold their values.
- R4: A byte whose D7..D5 value r is 0 to 4 writes the row r cell of character `char_addr`. Column Ci of that cell takes D(4-i), so D4 lands in column 0. The write gives a one-cycle `wr_en` pulse, with `wr_char` and `wr_row` naming the cell.
- R5: A byte with D7..D5 = 101 loads D2..D0 into `char_addr`. D4 and D3 are ignored.
- R6: Byte C0h sets every memory cell to 0 and leaves `char_addr`, `bright_lvl`, `lamp_test` and `power_down` unchanged.
- R7: Bytes F0h to F6h set `bright_lvl` to D2..D0, which gives levels 0 to 6. They also clear `lamp_test` and `power_down`.
- R8: Byte F8h sets `lamp_test` and leaves the memory unchanged.
- R9: Byte FFh sets `power_down`. Row writes are still stored and still pulse `wr_en` while `power_down` is set.
- R10: A frame with fewer or more than eight bits is decoded from the last eight bits shifted in. Those include bits left over from earlier frames.
- R11: The following bytes change no register and no memory cell, and give no `wr_en` pulse: F7h, F9h to FEh, E0h to EFh, and C1h to DFh.
- R12: `rd_cols` shows the cell at character `rd_char`, row `rd_row`, in the same cycle, with bit i = column Ci. It shows 0 when `rd_row` is above 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sdclk | input | 1 | Serial bit clock, asynchronous |
| sdata | input | 1 | Serial data bit, asynchronous |
| load | input | 1 | Frame strobe: low while shifting, rising edge triggers decode |
| rd_char | input | 3 | Read port character index |
| rd_row | input | 3 | Read port row index |
| rd_cols | output | 5 | Dots of the selected cell, bit i = column Ci |
| char_addr | output | 3 | Character addressed by row writes |
| bright_lvl | output | 3 | Brightness level, 0 = full |
| lamp_test | output | 1 | Lamp test active |
| power_down | output | 1 | Power down active |
| wr_en | output | 1 | One-cycle pulse per stored row write |
| wr_char | output | 3 | Character of the last row write |
| wr_row | output | 3 | Row of the last row write |

## Verification
The bench aims at the points where the byte fields meet. It writes rows through the column reversal, checking that D4 lands in column 0; a design that forgot the reversal would show mirror images of every glyph. It sends frames that are too short or too long, and clocks `sdclk` while `load` is high; a design that counted bits or ignored `load` would decode the wrong byte or take stray bits. It sends all the neighbours of the defined control words (F7h, the F9h to FEh range, E-prefix and nonzero C-prefix bytes); a loose decoder would change brightness or clear memory. It also writes rows during power down; a design that gated writes on that flag would lose them silently.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

    localparam int NUM_CHARS  = 8;
    localparam int NUM_ROWS   = 5;
    localparam int NUM_COLS   = 5;
    localparam int FRAME_BITS = 8;
    localparam int LEVEL_W    = 3;
    localparam int MAX_LEVEL  = 6;

    localparam int CHAR_AW = $clog2(NUM_CHARS);
    localparam int ROW_AW  = $clog2(NUM_ROWS);
    localparam int CELLS   = NUM_CHARS * NUM_ROWS;
    localparam int CELL_AW = $clog2(CELLS + NUM_ROWS * 2);

    typedef logic [FRAME_BITS-1:0] frame_t;
    typedef logic [NUM_COLS-1:0]   cols_t;

    typedef enum logic [2:0] {
        K_NONE,
        K_ROW,
        K_ADDR,
        K_CLEAR,
        K_LEVEL,
        K_LAMP,
        K_SLEEP
    } kind_e;

    typedef struct packed {
        kind_e               kind;
        logic [ROW_AW-1:0]   row;
        cols_t               cols;
        logic [CHAR_AW-1:0]  chr;
        logic [LEVEL_W-1:0]  level;
    } cmd_t;

    // Payload bit 4 is the leftmost dot, so column i takes payload bit (COLS-1-i).
    function automatic cols_t mirror_cols(input cols_t p);
        cols_t m;
        for (int i = 0; i < NUM_COLS; i++) begin
            m[i] = p[NUM_COLS-1-i];
        end
        return m;
    endfunction

    function automatic cmd_t decode_frame(input frame_t f);
        cmd_t        c;
        logic [2:0]  opc;
        logic [4:0]  pay;
        opc     = f[7:5];
        pay     = f[4:0];
        c       = '0;
        c.kind  = K_NONE;
        c.row   = opc[ROW_AW-1:0];
        c.cols  = mirror_cols(pay);
        c.chr   = pay[CHAR_AW-1:0];
        c.level = pay[LEVEL_W-1:0];
        if (int'(opc) < NUM_ROWS) begin
            c.kind = K_ROW;
        end else if (opc == 3'b101) begin
            c.kind = K_ADDR;
        end else if (opc == 3'b110) begin
            if (pay == 5'd0) c.kind = K_CLEAR;
        end else if (pay[4]) begin
            if (!pay[3] && (int'(pay[2:0]) <= MAX_LEVEL)) c.kind = K_LEVEL;
            else if (pay[3:0] == 4'b1000)                 c.kind = K_LAMP;
            else if (pay[3:0] == 4'b1111)                 c.kind = K_SLEEP;
        end
        return c;
    endfunction

endpackage

// File: rtl/sdd_sync.sv
module sdd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/sdd_frontend.sv
module sdd_frontend
    import sdd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   sdclk,
    input  logic   sdata,
    input  logic   load,
    output frame_t frame,
    output logic   frame_end
);
    logic clk_s, dat_s, ld_s;
    logic clk_d, ld_d;
    logic shift_fire;

    sdd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
        .clk(clk), .rst(rst), .din(sdclk), .dout(clk_s));
    sdd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
        .clk(clk), .rst(rst), .din(sdata), .dout(dat_s));
    // Idle level of the strobe is high: reset it high so leaving reset is no edge.
    sdd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ld (
        .clk(clk), .rst(rst), .din(load), .dout(ld_s));

    assign shift_fire = clk_s & ~clk_d & ~ld_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_d     <= 1'b0;
            ld_d      <= 1'b1;
            frame     <= '0;
            frame_end <= 1'b0;
        end else begin
            clk_d     <= clk_s;
            ld_d      <= ld_s;
            frame_end <= ld_s & ~ld_d;
            if (shift_fire) begin
                frame <= {dat_s, frame[FRAME_BITS-1:1]};
            end
        end
    end
endmodule

// File: rtl/sdd_store.sv
module sdd_store
    import sdd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  frame_t             frame,
    input  logic               frame_end,
    input  logic [CHAR_AW-1:0] rd_char,
    input  logic [ROW_AW-1:0]  rd_row,
    output cols_t              rd_cols,
    output logic [CHAR_AW-1:0] char_addr,
    output logic [LEVEL_W-1:0] bright_lvl,
    output logic               lamp_test,
    output logic               power_down,
    output logic               wr_en,
    output logic [CHAR_AW-1:0] wr_char,
    output logic [ROW_AW-1:0]  wr_row
);
    cols_t              mem [CELLS];
    cmd_t               cmd;
    logic [CELL_AW-1:0] wr_idx;
    logic [CELL_AW-1:0] rd_idx;

    assign cmd    = decode_frame(frame);
    assign wr_idx = CELL_AW'(char_addr) * CELL_AW'(NUM_ROWS) + CELL_AW'(cmd.row);
    assign rd_idx = CELL_AW'(rd_char) * CELL_AW'(NUM_ROWS) + CELL_AW'(rd_row);

    always_comb begin
        rd_cols = '0;
        if (int'(rd_row) < NUM_ROWS) rd_cols = mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CELLS; i++) mem[i] <= '0;
            char_addr  <= '0;
            bright_lvl <= '0;
            lamp_test  <= 1'b0;
            power_down <= 1'b0;
            wr_en      <= 1'b0;
            wr_char    <= '0;
            wr_row     <= '0;
        end else begin
            wr_en <= 1'b0;
            if (frame_end) begin
                unique case (cmd.kind)
                    K_ROW: begin
                        mem[wr_idx] <= cmd.cols;
                        wr_en       <= 1'b1;
                        wr_char     <= char_addr;
                        wr_row      <= cmd.row;
                    end
                    K_ADDR:  char_addr <= cmd.chr;
                    K_CLEAR: for (int i = 0; i < CELLS; i++) mem[i] <= '0;
                    K_LEVEL: begin
                        bright_lvl <= cmd.level;
                        lamp_test  <= 1'b0;
                        power_down <= 1'b0;
                    end
                    K_LAMP:  lamp_test  <= 1'b1;
                    K_SLEEP: power_down <= 1'b1;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sdd_cmd_decoder.sv
module sdd_cmd_decoder
    import sdd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sdclk,
    input  logic               sdata,
    input  logic               load,
    input  logic [CHAR_AW-1:0] rd_char,
    input  logic [ROW_AW-1:0]  rd_row,
    output logic [NUM_COLS-1:0] rd_cols,
    output logic [CHAR_AW-1:0] char_addr,
    output logic [LEVEL_W-1:0] bright_lvl,
    output logic               lamp_test,
    output logic               power_down,
    output logic               wr_en,
    output logic [CHAR_AW-1:0] wr_char,
    output logic [ROW_AW-1:0]  wr_row
);
    frame_t frame_q;
    logic   frame_end;

    sdd_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk       (clk),
        .rst       (rst),
        .sdclk     (sdclk),
        .sdata     (sdata),
        .load      (load),
        .frame     (frame_q),
        .frame_end (frame_end)
    );

    sdd_store u_store (
        .clk        (clk),
        .rst        (rst),
        .frame      (frame_q),
        .frame_end  (frame_end),
        .rd_char    (rd_char),
        .rd_row     (rd_row),
        .rd_cols    (rd_cols),
        .char_addr  (char_addr),
        .bright_lvl (bright_lvl),
        .lamp_test  (lamp_test),
        .power_down (power_down),
        .wr_en      (wr_en),
        .wr_char    (wr_char),
        .wr_row     (wr_row)
    );
endmodule

// File: rtl/sdd_cmd_decoder_checker.sv
module sdd_cmd_decoder_checker
    import sdd_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input frame_t             frame,
    input logic               frame_end,
    input logic [CHAR_AW-1:0] char_addr,
    input logic [LEVEL_W-1:0] bright_lvl,
    input logic               lamp_test,
    input logic               power_down,
    input logic               wr_en
);
    cmd_t c;
    assign c = decode_frame(frame);

    a_r3_regs_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> ($stable(char_addr) && $stable(bright_lvl)
                        && $stable(lamp_test) && $stable(power_down)));

    a_r7_level_range: assert property (@(posedge clk) disable iff (rst)
        int'(bright_lvl) <= MAX_LEVEL);

    a_r7_level_wakes: assert property (@(posedge clk) disable iff (rst)
        (frame_end && c.kind == K_LEVEL) |=>
            (!lamp_test && !power_down && bright_lvl == $past(frame[2:0])));

    a_r5_addr_load: assert property (@(posedge clk) disable iff (rst)
        (frame_end && c.kind == K_ADDR) |=> (char_addr == $past(frame[2:0])));

    a_r9_row_write_strobe: assert property (@(posedge clk) disable iff (rst)
        (frame_end && c.kind == K_ROW) |=> wr_en);

    a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    a_r11_no_stray_strobe: assert property (@(posedge clk) disable iff (rst)
        (frame_end && c.kind != K_ROW) |=> !wr_en);
endmodule

bind sdd_cmd_decoder sdd_cmd_decoder_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame      (frame_q),
    .frame_end  (frame_end),
    .char_addr  (char_addr),
    .bright_lvl (bright_lvl),
    .lamp_test  (lamp_test),
    .power_down (power_down),
    .wr_en      (wr_en)
);

// File: tb/sdd_cmd_decoder_bench.sv
module sdd_cmd_decoder_bench;
    logic       clk = 1'b0;
    logic       rst, sdclk, sdata, load;
    logic [2:0] rd_char, rd_row;
    logic [4:0] rd_cols;
    logic [2:0] char_addr, bright_lvl, wr_char, wr_row;
    logic       lamp_test, power_down, wr_en;

    always #2 clk = ~clk;

    sdd_cmd_decoder u_sdd_cmd_decoder (
        .clk(clk), .rst(rst), .sdclk(sdclk), .sdata(sdata), .load(load),
        .rd_char(rd_char), .rd_row(rd_row), .rd_cols(rd_cols),
        .char_addr(char_addr), .bright_lvl(bright_lvl), .lamp_test(lamp_test),
        .power_down(power_down), .wr_en(wr_en), .wr_char(wr_char), .wr_row(wr_row)
    );

    // Reference state built from the requirements
    logic [4:0] m_ram [8][5];
    logic [2:0] m_addr, m_lvl;
    logic       m_lt, m_pd;
    logic [7:0] m_sr;
    int         n_checks = 0, n_fail = 0;
    bit         done = 0;
    int         wr_seen = 0;
    logic [2:0] wr_c_seen, wr_r_seen;

    always @(posedge clk) begin
        if (!rst && wr_en) begin
            wr_seen   = wr_seen + 1;
            wr_c_seen = wr_char;
            wr_r_seen = wr_row;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] flip5(input logic [4:0] p);
        logic [4:0] m;
        for (int i = 0; i < 5; i++) m[i] = p[4-i];
        return m;
    endfunction

    task automatic model_apply(input logic [7:0] b, output int expw);
        expw = 0;
        if (b[7:5] <= 3'd4) begin
            m_ram[m_addr][b[7:5]] = flip5(b[4:0]);
            expw = 1;
        end else if (b[7:5] == 3'd5) begin
            m_addr = b[2:0];
        end else if (b == 8'hC0) begin
            for (int c = 0; c < 8; c++)
                for (int r = 0; r < 5; r++) m_ram[c][r] = 5'd0;
        end else if (b >= 8'hF0 && b <= 8'hF6) begin
            m_lvl = b[2:0]; m_lt = 1'b0; m_pd = 1'b0;
        end else if (b == 8'hF8) begin
            m_lt = 1'b1;
        end else if (b == 8'hFF) begin
            m_pd = 1'b1;
        end
    endtask

    task automatic check_state(input string req);
        chk(req, "char_addr",  32'(char_addr),  32'(m_addr));
        chk(req, "bright_lvl", 32'(bright_lvl), 32'(m_lvl));
        chk(req, "lamp_test",  32'(lamp_test),  32'(m_lt));
        chk(req, "power_down", 32'(power_down), 32'(m_pd));
    endtask

    task automatic check_cell(input int c, input int r, input string req);
        @(negedge clk);
        rd_char = 3'(c);
        rd_row  = 3'(r);
        @(negedge clk);
        chk(req, $sformatf("cell c%0d r%0d", c, r), 32'(rd_cols), 32'(m_ram[c][r]));
    endtask

    task automatic sweep(input string req);
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 5; r++) check_cell(c, r, req);
    endtask

    task automatic pulse_bit(input logic b);
        @(negedge clk) sdata = b;
        repeat (2) @(negedge clk);
        sdclk = 1'b1;
        repeat (4) @(negedge clk);
        sdclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Sends nbits LSB first, then raises load and checks the result.
    task automatic send(input int nbits, input logic [15:0] bits, input string req);
        int expw;
        @(negedge clk) load = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            pulse_bit(bits[i]);
            m_sr = {bits[i], m_sr[7:1]};
        end
        repeat (2) @(negedge clk);
        wr_seen = 0;
        load = 1'b1;
        repeat (12) @(negedge clk);
        model_apply(m_sr, expw);
        check_state(req);
        chk(req, "write strobes", 32'(wr_seen), 32'(expw));
        if (expw == 1) begin
            chk("R4", "wr_char", 32'(wr_c_seen), 32'(m_addr));
            chk("R4", "wr_row",  32'(wr_r_seen), 32'(m_sr[7:5]));
            check_cell(int'(m_addr), int'(m_sr[7:5]), req);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input string req);
        send(8, {8'h00, b}, req);
    endtask

    task automatic stray_clocks(input int n);
        for (int i = 0; i < n; i++) pulse_bit(1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int          sel;
        logic [7:0]  b;
        seed = 32'd1234;
        void'($urandom(seed));
        rst = 1'b1; load = 1'b1; sdclk = 1'b0; sdata = 1'b0;
        rd_char = '0; rd_row = '0;
        m_addr = '0; m_lvl = '0; m_lt = 1'b0; m_pd = 1'b0; m_sr = '0;
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 5; r++) m_ram[c][r] = 5'd0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset state
        check_state("R1");
        chk("R1", "wr_en", 32'(wr_en), 32'd0);
        sweep("R1");

        // R5 address with ignored upper payload bits, R4 glyph rows
        send_byte(8'hBB, "R5");
        send_byte(8'h1E, "R4");
        send_byte(8'h31, "R4");
        send_byte(8'h51, "R4");
        send_byte(8'h71, "R4");
        send_byte(8'h9E, "R4");
        check_cell(3, 0, "R4");

        // R12: rows above 4 read as zero
        @(negedge clk); rd_char = 3'd3; rd_row = 3'd6;
        @(negedge clk); chk("R12", "row 6 read", 32'(rd_cols), 32'd0);

        // R9: power down, writes still land
        send_byte(8'hFF, "R9");
        send_byte(8'hA6, "R5");
        send_byte(8'h4A, "R9");
        // R8: lamp test leaves memory alone
        send_byte(8'hF8, "R8");
        sweep("R8");
        // R7: brightness wakes and cancels lamp test
        send_byte(8'hF3, "R7");
        send_byte(8'hF6, "R7");

        // R11: undefined control words
        send_byte(8'hF7, "R11");
        send_byte(8'hFB, "R11");
        send_byte(8'hFE, "R11");
        send_byte(8'hC4, "R11");
        send_byte(8'hE5, "R11");
        send_byte(8'hD0, "R11");
        sweep("R11");

        // R10: short and long frames use the last eight bits
        send(3, 16'h0005, "R10");
        send(11, 16'h05A7, "R10");
        send(5, 16'h0011, "R10");

        // R2: clocks while load is high are ignored
        stray_clocks(5);
        check_state("R2");
        send(2, 16'h0002, "R2");

        // R6: software clear
        send_byte(8'hA2, "R5");
        send_byte(8'h7F, "R4");
        send_byte(8'hC0, "R6");
        sweep("R6");
        send_byte(8'hF0, "R7");

        // Constrained random mix
        for (int n = 0; n < 300; n++) begin
            sel = int'($urandom_range(0, 99));
            if (sel < 40)      b = {3'($urandom_range(0, 4)), 5'($urandom)};
            else if (sel < 55) b = {3'b101, 5'($urandom)};
            else if (sel < 65) b = 8'hF0 + 8'($urandom_range(0, 6));
            else if (sel < 70) b = 8'hF8;
            else if (sel < 75) b = 8'hFF;
            else if (sel < 78) b = 8'hC0;
            else               b = 8'($urandom);
            if ($urandom_range(0, 9) == 0)
                send(int'($urandom_range(1, 12)), 16'($urandom), "R10");
            else
                send_byte(b, "R3");
            if ((n % 5) == 0)
                check_cell(int'($urandom_range(0, 7)), int'($urandom_range(0, 4)), "R12");
        end
        sweep("R12");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule